// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This block decides when a vehicle's belt reminder should beep. Once the ignition key goes on, a grace period of a few seconds runs. If the belt is still open when that period ends and the key is still on, the alarm starts. The alarm then sounds for a bounded time. Fastening the belt or turning the key off ends it early. If either happens during the grace period, the alarm never starts.

Two synchronous machines make up the block, and both change state on the same clock edge. The first is a three-state Mealy controller with the states idle, grace and sounding. The second is a seconds timer that has its own prescaler, dividing the system clock by a parameterised number of cycles per second. The controller starts and stops the timer through a small command struct. The timer sends back one-cycle indications at the end of the grace time and at the end of the total time.

The outputs are three one-cycle event pulses and a level that drives the sounder: start-timer, alarm-on and alarm-off are the pulses, and beeping is the level. The event inputs are single-cycle pulses from already debounced switch logic. In the requirements below, cycle 0 is the cycle in which start-timer is high, CPS is `CLKS_PER_SEC`, G is `GRACE_SECS` (default 5) and S is `STOP_SECS` (default 10).

Top module: `belt_alarm_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, startTimer, alarmOn, alarmOff and beeping are all low, and the controller is idle.
- R2: In idle, keyOn raises startTimer combinationally in the same cycle and moves the controller to grace. Without keyOn, keyOff and beltOn have no effect, the controller stays idle and every output stays low.
- R3: In grace, keyOff or beltOn returns the controller to idle with no output pulse in that cycle.
- R4: If the grace period runs out undisturbed, alarmOn is high in exactly cycle G*CPS+1 and in no earlier cycle.
- R5: While sounding, beltOn or keyOff raises alarmOff in the same cycle, and beeping is low from the next cycle.
- R6: If nothing interrupts it, alarmOff is high in cycle S*CPS+1. This gives exactly (S-G)*CPS beeping cycles.
- R7: keyOn has no effect outside idle: it produces no startTimer pulse and does not shift the alarm timing.
- R8: In grace, keyOff or beltOn in the same cycle as the end of the grace time takes priority, so alarmOn stays low and the alarm never starts.
- R9: beeping is high exactly from the cycle after alarmOn through the cycle that carries alarmOff.
- R10: startTimer clears the seconds count and the prescaler. A run started right after an early abort is timed from its own start, not from the aborted one.
- R11: Once the controller returns to idle, the timer stays silent: no alarmOn or alarmOff pulse appears while no new run is started.
- R12: Each of startTimer, alarmOn and alarmOff is high for a single cycle per event, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyOn | input | 1 | One-cycle ignition-on event |
| keyOff | input | 1 | One-cycle ignition-off event |
| beltOn | input | 1 | One-cycle belt-fastened event |
| startTimer | output | 1 | Pulse: grace timing started |
| alarmOn | output | 1 | Pulse: alarm begins |
| alarmOff | output | 1 | Pulse: alarm ends |
| beeping | output | 1 | Level: sounder should be active |

## Verification
A wrong controller state shows at the ports within one cycle, because the event pulses are Mealy functions of the state. A stray grace or sounding state either swallows a key-on pulse or leaves beeping at the wrong level on the next sample. A wrong timer count or prescaler value shows up only when an end indication should fire. It moves alarmOn or alarmOff away from cycle G*CPS+1 or S*CPS+1, so checks sit on those exact cycles and on the cycles just before them. A timer that was not stopped shows up later, as a stray pulse during long idle windows after each abort.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_GRACE = 2'd1,
    CTL_SOUND = 2'd2
  } ctlState_t;

  // Strobes sent from the controller to the timer datapath.
  typedef struct packed {
    logic startTimer;
    logic stopTimer;
  } timerCmd_t;

endpackage

// File: rtl/belt_sec_tick.sv
module belt_sec_tick #(
  parameter int CLKS_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic enable,
  output logic tick
);

  localparam int PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_SEC - 1);

  logic [PRE_W-1:0] preCount;

  assign tick = enable && (preCount == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCount <= '0;
    end else if (clear) begin
      preCount <= '0;
    end else if (enable) begin
      if (preCount == PRE_LAST) preCount <= '0;
      else                      preCount <= preCount + PRE_W'(1);
    end
  end

  assert_pre_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    preCount <= PRE_LAST);

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (preCount == '0));

endmodule

// File: rtl/belt_timer_path.sv
module belt_timer_path
  import belt_alarm_pkg::*;
#(
  parameter int CLKS_PER_SEC = 50_000_000,
  parameter int GRACE_SECS   = 5,
  parameter int STOP_SECS    = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      graceDone,
  output logic      soundDone
);

  localparam int SEC_W = $clog2(STOP_SECS + 1);
  localparam logic [SEC_W-1:0] GRACE_CNT = SEC_W'(GRACE_SECS);
  localparam logic [SEC_W-1:0] STOP_CNT  = SEC_W'(STOP_SECS);

  logic             running;
  logic             secTick;
  logic [SEC_W-1:0] secCount;
  logic [SEC_W-1:0] secNext;

  assign secNext = secCount + SEC_W'(1);

  belt_sec_tick #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_tick (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (cmd.startTimer),
    .enable (running),
    .tick   (secTick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      secCount  <= '0;
      graceDone <= 1'b0;
      soundDone <= 1'b0;
    end else if (cmd.startTimer) begin
      running   <= 1'b1;
      secCount  <= '0;
      graceDone <= 1'b0;
      soundDone <= 1'b0;
    end else if (cmd.stopTimer) begin
      running   <= 1'b0;
      graceDone <= 1'b0;
      soundDone <= 1'b0;
    end else begin
      graceDone <= 1'b0;
      soundDone <= 1'b0;
      if (secTick) begin
        secCount  <= secNext;
        graceDone <= (secNext == GRACE_CNT);
        soundDone <= (secNext == STOP_CNT);
        if (secNext == STOP_CNT) running <= 1'b0;
      end
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    secCount <= STOP_CNT);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startTimer |=> (secCount == '0) && !graceDone && !soundDone);

  assert_stop_silences_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stopTimer |=> !graceDone && !soundDone);

  assert_grace_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    graceDone |=> !graceDone);

  assert_sound_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    soundDone |=> !soundDone);

endmodule

// File: rtl/belt_ctl_fsm.sv
module belt_ctl_fsm
  import belt_alarm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      keyOn,
  input  logic      keyOff,
  input  logic      beltOn,
  input  logic      graceDone,
  input  logic      soundDone,
  output timerCmd_t cmd,
  output logic      startTimer,
  output logic      alarmOn,
  output logic      alarmOff,
  output logic      beeping
);

  ctlState_t state, nextState;

  always_comb begin
    nextState  = state;
    startTimer = 1'b0;
    alarmOn    = 1'b0;
    alarmOff   = 1'b0;
    cmd        = '0;
    unique case (state)
      CTL_IDLE: begin
        if (keyOn) begin
          nextState      = CTL_GRACE;
          startTimer     = 1'b1;
          cmd.startTimer = 1'b1;
        end
      end
      CTL_GRACE: begin
        if (keyOff || beltOn) begin
          nextState     = CTL_IDLE;
          cmd.stopTimer = 1'b1;
        end else if (graceDone) begin
          nextState = CTL_SOUND;
          alarmOn   = 1'b1;
        end
      end
      CTL_SOUND: begin
        if (beltOn || keyOff || soundDone) begin
          nextState     = CTL_IDLE;
          alarmOff      = 1'b1;
          cmd.stopTimer = 1'b1;
        end
      end
      default: nextState = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CTL_IDLE;
    else       state <= nextState;
  end

  assign beeping = (state == CTL_SOUND);

  assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startTimer, alarmOn, alarmOff}));

  assert_enter_sound_R9: assert property (@(posedge clk) disable iff (!rstN)
    alarmOn |=> beeping);

  assert_leave_sound_R5: assert property (@(posedge clk) disable iff (!rstN)
    alarmOff |=> !beeping);

  assert_beep_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(beeping) |-> $past(alarmOn));

  assert_abort_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyOff || beltOn) |-> !alarmOn);

  assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    startTimer |=> !startTimer && !beeping);

endmodule

// File: rtl/belt_alarm_top.sv
module belt_alarm_top
  import belt_alarm_pkg::*;
#(
  parameter int CLKS_PER_SEC = 50_000_000,
  parameter int GRACE_SECS   = 5,
  parameter int STOP_SECS    = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyOn,
  input  logic keyOff,
  input  logic beltOn,
  output logic startTimer,
  output logic alarmOn,
  output logic alarmOff,
  output logic beeping
);

  timerCmd_t timerCmd;
  logic      graceDone;
  logic      soundDone;

  belt_ctl_fsm u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .keyOn      (keyOn),
    .keyOff     (keyOff),
    .beltOn     (beltOn),
    .graceDone  (graceDone),
    .soundDone  (soundDone),
    .cmd        (timerCmd),
    .startTimer (startTimer),
    .alarmOn    (alarmOn),
    .alarmOff   (alarmOff),
    .beeping    (beeping)
  );

  belt_timer_path #(
    .CLKS_PER_SEC (CLKS_PER_SEC),
    .GRACE_SECS   (GRACE_SECS),
    .STOP_SECS    (STOP_SECS)
  ) u_timer (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (timerCmd),
    .graceDone (graceDone),
    .soundDone (soundDone)
  );

endmodule

// File: tb/belt_alarm_top_test.sv
module belt_alarm_top_test;

  localparam int CPS = 4;
  localparam int G   = 5;
  localparam int S   = 10;
  localparam int T5  = G * CPS + 1;
  localparam int T10 = S * CPS + 1;

  localparam logic [2:0] EV_NONE   = 3'b000;
  localparam logic [2:0] EV_KEYON  = 3'b001;
  localparam logic [2:0] EV_KEYOFF = 3'b010;
  localparam logic [2:0] EV_BELT   = 3'b100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyOn = 1'b0, keyOff = 1'b0, beltOn = 1'b0;
  logic startTimer, alarmOn, alarmOff, beeping;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  belt_alarm_top #(.CLKS_PER_SEC(CPS), .GRACE_SECS(G), .STOP_SECS(S)) uut (
    .clk(clk), .rstN(rstN), .keyOn(keyOn), .keyOff(keyOff), .beltOn(beltOn),
    .startTimer(startTimer), .alarmOn(alarmOn), .alarmOff(alarmOff), .beeping(beeping)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive events at the falling edge, sample shortly after.
  task automatic cycleWith(input logic [2:0] ev);
    @(negedge clk);
    {beltOn, keyOff, keyOn} = ev;
    #2;
  endtask

  task automatic idleRun(input int n, output int st, output int on, output int off, output int bp);
    st = 0; on = 0; off = 0; bp = 0;
    for (int i = 0; i < n; i++) begin
      cycleWith(EV_NONE);
      st += int'(startTimer); on += int'(alarmOn);
      off += int'(alarmOff);  bp += int'(beeping);
    end
  endtask

  task automatic startRun(input string req);
    cycleWith(EV_KEYON);
    check(req, "startTimer on key-on", int'(startTimer), 1);
  endtask

  task automatic cleanup();
    cycleWith(EV_KEYOFF);
    cycleWith(EV_NONE);
    cycleWith(EV_NONE);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    #2;
    check("R1", "startTimer in reset", int'(startTimer), 0);
    check("R1", "beeping in reset", int'(beeping), 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check("R1", "outputs after reset", int'({startTimer, alarmOn, alarmOff, beeping}), 0);
  endtask

  task automatic testIdle();
    int st, on, off, bp;
    cycleWith(EV_KEYOFF);
    check("R2", "idle key-off outputs", int'({startTimer, alarmOn, alarmOff, beeping}), 0);
    cycleWith(EV_BELT);
    check("R2", "idle belt outputs", int'({startTimer, alarmOn, alarmOff, beeping}), 0);
    idleRun(3 * CPS, st, on, off, bp);
    check("R2", "idle pulses", st + on + off + bp, 0);
  endtask

  task automatic testFullRun();
    int st, on, off, bp;
    startRun("R2");
    idleRun(1, st, on, off, bp);
    check("R12", "startTimer single cycle", st, 0);
    idleRun(T5 - 2, st, on, off, bp);
    check("R4", "no early alarmOn", on, 0);
    check("R4", "no early beeping", bp, 0);
    cycleWith(EV_NONE);
    check("R4", "alarmOn at grace end", int'(alarmOn), 1);
    check("R9", "beeping low with alarmOn", int'(beeping), 0);
    cycleWith(EV_NONE);
    check("R12", "alarmOn single cycle", int'(alarmOn), 0);
    check("R9", "beeping after alarmOn", int'(beeping), 1);
    idleRun(T10 - T5 - 2, st, on, off, bp);
    check("R6", "beeping held", bp, T10 - T5 - 2);
    check("R6", "no early alarmOff", off, 0);
    cycleWith(EV_NONE);
    check("R6", "alarmOff at stop time", int'(alarmOff), 1);
    check("R9", "beeping in alarmOff cycle", int'(beeping), 1);
    cycleWith(EV_NONE);
    check("R9", "beeping ends", int'(beeping), 0);
    check("R12", "alarmOff single cycle", int'(alarmOff), 0);
    idleRun(12 * CPS, st, on, off, bp);
    check("R11", "silent after run", st + on + off + bp, 0);
  endtask

  task automatic testGraceAbort(input logic [2:0] ev);
    int st, on, off, bp;
    startRun("R2");
    idleRun(2 * CPS, st, on, off, bp);
    cycleWith(ev);
    check("R3", "no pulse on grace abort", int'({startTimer, alarmOn, alarmOff}), 0);
    idleRun(12 * CPS, st, on, off, bp);
    check("R11", "silent after grace abort", on + off + bp, 0);
    startRun("R3");
    cleanup();
  endtask

  task automatic testPriority(input logic [2:0] ev);
    int st, on, off, bp;
    startRun("R2");
    idleRun(T5 - 1, st, on, off, bp);
    cycleWith(ev);
    check("R8", "abort beats grace end", int'(alarmOn), 0);
    check("R8", "no alarmOff on abort", int'(alarmOff), 0);
    idleRun(8 * CPS, st, on, off, bp);
    check("R8", "alarm never starts", on + off + bp, 0);
  endtask

  task automatic testAlarmAbort(input logic [2:0] ev);
    int st, on, off, bp;
    startRun("R2");
    idleRun(T5 - 1, st, on, off, bp);
    cycleWith(EV_NONE);
    check("R4", "alarmOn reached", int'(alarmOn), 1);
    idleRun(2 * CPS, st, on, off, bp);
    cycleWith(ev);
    check("R5", "alarmOff on abort", int'(alarmOff), 1);
    check("R9", "beeping in abort cycle", int'(beeping), 1);
    cycleWith(EV_NONE);
    check("R5", "beeping low after abort", int'(beeping), 0);
    idleRun(8 * CPS, st, on, off, bp);
    check("R11", "silent after alarm abort", on + off + bp, 0);
    startRun("R5");
    cleanup();
  endtask

  task automatic testKeyOnIgnored();
    int st, on, off, bp;
    startRun("R2");
    idleRun(CPS, st, on, off, bp);
    cycleWith(EV_KEYON);
    check("R7", "keyOn in grace ignored", int'(startTimer), 0);
    idleRun(T5 - CPS - 2, st, on, off, bp);
    check("R7", "no early alarmOn", on, 0);
    cycleWith(EV_NONE);
    check("R7", "grace timing kept", int'(alarmOn), 1);
    cycleWith(EV_KEYON);
    check("R7", "keyOn in alarm ignored", int'(startTimer), 0);
    check("R7", "beeping kept", int'(beeping), 1);
    idleRun(T10 - T5 - 2, st, on, off, bp);
    check("R7", "no early alarmOff", off, 0);
    cycleWith(EV_NONE);
    check("R7", "stop timing kept", int'(alarmOff), 1);
    cleanup();
  endtask

  task automatic testRestart();
    int st, on, off, bp;
    startRun("R2");
    idleRun(3 * CPS, st, on, off, bp);
    cycleWith(EV_BELT);
    startRun("R10");
    idleRun(T5 - 1, st, on, off, bp);
    check("R10", "no alarm from old count", on, 0);
    cycleWith(EV_NONE);
    check("R10", "alarmOn timed from restart", int'(alarmOn), 1);
    cleanup();
  endtask

  initial begin
    testReset();
    testIdle();
    testFullRun();
    testGraceAbort(EV_BELT);
    testGraceAbort(EV_KEYOFF);
    testPriority(EV_KEYOFF);
    testPriority(EV_BELT);
    testAlarmAbort(EV_BELT);
    testAlarmAbort(EV_KEYOFF);
    testKeyOnIgnored();
    testRestart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule